// File: doc/BRIEF.md
# Toggle Event Schedule Generator

This block turns a bank of twelve square-wave tone channels into a compact stream of timed toggle events. It does not count time tick by tick. Each channel keeps a down-counter of the half-period time units left until it next flips. On every pass the block finds the channel closest to expiry, moves every counter forward by that amount, reloads the channels that reach zero, and records which ones flipped. The result is a sequence of events. Each event holds a 12-bit toggle mask and an 8-bit delay. A playback stage waits for the delay and then flips the masked pins.

Channels with an odd full period get asymmetric halves: their reload value alternates between a base value and that value plus one. The mask carried by an event always belongs to the previous pass, so the delay paired with it elapses before the bits are applied. Events leave through a valid/ready write port into a 64-slot ring buffer held outside the block. The block also reports the slot index for each event, and it waits while the buffer has no room.

A pass walks the channels one per clock, then offers the event. When the buffer accepts at once, a new event appears every 13 cycles.

Top module: `tone_event_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to its start state. `evValid` is low and `evSlot` is 0. The event stream after release is identical to the stream from power-up.
- R2: The first event after reset has an all-zero mask and a delay field of 118.
- R3: Bit i of the mask (bit 0 is channel 0) in event k is 1 exactly when channel i expires at time S(k-1). S(k-1) is the sum of (delay+1) over events 0..k-1, and S(-1) = 0. The first expiries of channels 0..11 are at 119, 126, 134, 142, 150, 159, 169, 179, 189, 201, 213 and 225.
- R4: The delay field equals the time from S(k-1) to the earliest expiry of any channel after S(k-1), minus one. A stored 0 therefore means one time unit.
- R5: Channels 0, 1, 4, 5, 8 and 11 are odd. For an odd channel with first expiry c, the intervals between expiries are c, c+1, c, c+1 and so on. For the other channels every interval is c.
- R6: While `evValid` is high and `evReady` is low, `evValid` stays high and `evMask`, `evDelay` and `evSlot` hold their values.
- R7: `evSlot` is 0 for the first event after reset. It advances by one, modulo 64, for each accepted event.
- R8: After an event is accepted, `evValid` stays low for exactly 12 cycles before the next event is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evReady | input | 1 | Ring buffer can take an event |
| evValid | output | 1 | An event is offered |
| evMask | output | 12 | Channels to toggle when the event is applied |
| evDelay | output | 8 | Time units to wait before applying, minus one |
| evSlot | output | 6 | Ring-buffer slot for this event |

## Verification
The bench predicts every channel's expiry instants arithmetically and compares each accepted event against that schedule over several full cycles of the slowest channel. A design that paired a mask with its own pass's delay would flip bits one event early. A design that got the reload-then-add order wrong for odd channels would show interval pairs such as c+1, c where c, c+1 is expected. An off-by-one in the delay encoding would stretch the whole schedule. The ready input is held low on an irregular pattern so that stalls land both mid-run and across the slot wrap, where a design that advanced its slot or state without a handshake would skip or lose an event. A reset is applied mid-stream to confirm that the counts, terminal counts and phases all return to their start values.

// File: rtl/tog_pkg.sv
package tog_pkg;
  localparam int NUM_CH = 12;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 64;
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam logic [CNT_W-1:0] MIN_SEED = '1;

  typedef struct packed {
    logic             scan;    // process channel idx this cycle
    logic [IDX_W-1:0] idx;     // channel being processed
    logic             commit;  // event accepted: roll pass results over
  } ctrl_t;

  function automatic logic [CNT_W-1:0] initCount(int i);
    case (i)
      0: return CNT_W'(119);  1: return CNT_W'(126);  2: return CNT_W'(134);
      3: return CNT_W'(142);  4: return CNT_W'(150);  5: return CNT_W'(159);
      6: return CNT_W'(169);  7: return CNT_W'(179);  8: return CNT_W'(189);
      9: return CNT_W'(201); 10: return CNT_W'(213); default: return CNT_W'(225);
    endcase
  endfunction

  function automatic logic initOdd(int i);
    return (i == 0) || (i == 1) || (i == 4) || (i == 5) || (i == 8) || (i == 11);
  endfunction

  function automatic logic [CNT_W-1:0] smallestInit();
    logic [CNT_W-1:0] m;
    m = '1;
    for (int i = 0; i < NUM_CH; i++)
      if (initCount(i) < m) m = initCount(i);
    return m;
  endfunction
endpackage

// File: rtl/tog_control.sv
module tog_control
  import tog_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  evReady,
  output logic  evValid,
  output ctrl_t ctrl
);
  typedef enum logic {S_SCAN, S_EMIT} state_t;
  state_t state;
  logic [IDX_W-1:0] idx;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_SCAN;
      idx   <= '0;
    end else begin
      case (state)
        S_SCAN: begin
          if (idx == LAST) begin
            state <= S_EMIT;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          if (evReady) state <= S_SCAN;
        end
      endcase
    end
  end

  assign evValid     = (state == S_EMIT);
  assign ctrl.scan   = (state == S_SCAN);
  assign ctrl.idx    = idx;
  assign ctrl.commit = evValid && evReady;

  // R6: an offered event is not withdrawn before acceptance
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
    evValid && !evReady |=> evValid);
  // R8: scanning never addresses a channel beyond the last one
  p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.scan |-> idx <= LAST);
  // R8: acceptance always starts a fresh scan at channel 0
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    evValid && evReady |=> ctrl.scan && idx == '0);
endmodule

// File: rtl/tog_datapath.sv
module tog_datapath
  import tog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [NUM_CH-1:0] prevMask,
  output logic [CNT_W-1:0]  minVal,
  output logic [SLOT_W-1:0] slot
);
  logic [CNT_W-1:0]  cnt [NUM_CH];
  logic [CNT_W-1:0]  tc  [NUM_CH];
  logic [1:0]        ph  [NUM_CH];   // two's complement: 0, +1 or -1
  logic [NUM_CH-1:0] togAcc;
  logic [CNT_W-1:0]  nextMin;

  logic [CNT_W-1:0] cntSel, tcSel, diff, postVal;
  logic             hit;

  assign cntSel  = cnt[ctrl.idx];
  assign tcSel   = tc[ctrl.idx];
  assign diff    = cntSel - minVal;
  assign hit     = (diff == '0);
  assign postVal = hit ? tcSel : diff;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic sel;
    assign sel = ctrl.scan && (ctrl.idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g] <= initCount(g);
        tc[g]  <= initCount(g);
        ph[g]  <= {1'b0, initOdd(g)};
      end else if (sel) begin
        if (hit) begin
          cnt[g] <= tc[g];
          tc[g]  <= tc[g] + {{(CNT_W-2){ph[g][1]}}, ph[g]};
          ph[g]  <= ~ph[g] + 2'd1;
        end else begin
          cnt[g] <= diff;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      togAcc   <= '0;
      nextMin  <= MIN_SEED;
      minVal   <= smallestInit();
      prevMask <= '0;
      slot     <= '0;
    end else if (ctrl.commit) begin
      minVal   <= nextMin;
      prevMask <= togAcc;
      togAcc   <= '0;
      nextMin  <= MIN_SEED;
      slot     <= slot + 1'b1;
    end else if (ctrl.scan) begin
      togAcc <= togAcc | (NUM_CH'(hit) << ctrl.idx);
      if (postVal < nextMin) nextMin <= postVal;
    end
  end

  // R4: the step never exceeds any remaining count
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.scan |-> cntSel >= minVal);
  // R4: a step is at least one time unit
  p_step_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    minVal != '0);
  // R5: an expiring channel reloads to a nonzero count
  p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.scan && hit |-> tcSel != '0);
endmodule

// File: rtl/tone_event_gen.sv
module tone_event_gen
  import tog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evReady,
  output logic              evValid,
  output logic [NUM_CH-1:0] evMask,
  output logic [CNT_W-1:0]  evDelay,
  output logic [SLOT_W-1:0] evSlot
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] minVal;

  tog_control i_ctrl (
    .clk(clk), .rst(rst), .evReady(evReady), .evValid(evValid), .ctrl(ctrl)
  );

  tog_datapath i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .prevMask(evMask), .minVal(minVal), .slot(evSlot)
  );

  assign evDelay = minVal - 1'b1;

  // R6: a stalled event keeps every field
  p_stall_stable_r6: assert property (@(posedge clk) disable iff (rst)
    evValid && !evReady |=> $stable(evMask) && $stable(evDelay) && $stable(evSlot));
  // R7: one slot step per accepted event
  p_slot_step_r7: assert property (@(posedge clk) disable iff (rst)
    evValid && evReady |=> evSlot == $past(evSlot) + 1'b1);
  // R7: no slot movement without acceptance
  p_slot_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(evValid && evReady) |=> $stable(evSlot));
endmodule

// File: tb/test_tone_event_gen.sv
module test_tone_event_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evReady = 1'b0;
  logic evValid;
  logic [11:0] evMask;
  logic [7:0]  evDelay;
  logic [5:0]  evSlot;

  always #4 clk = ~clk;   // 125 MHz

  tone_event_gen i_tone_event_gen (
    .clk(clk), .rst(rst), .evReady(evReady), .evValid(evValid),
    .evMask(evMask), .evDelay(evDelay), .evSlot(evSlot)
  );

  int nChecks = 0;
  int nFail = 0;

  // independent schedule model
  int base [12];
  bit odd [12];
  longint nextExp [12];
  int nExp [12];
  longint lastSeen [12];
  int seenCnt [12];
  longint tPrev;
  int evCount;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    int b [12] = '{119,126,134,142,150,159,169,179,189,201,213,225};
    for (int i = 0; i < 12; i++) begin
      base[i] = b[i];
      odd[i] = (i == 0 || i == 1 || i == 4 || i == 5 || i == 8 || i == 11);
      nextExp[i] = b[i];
      nExp[i] = 0;
      lastSeen[i] = 0;
      seenCnt[i] = 0;
    end
    tPrev = 0;
    evCount = 0;
  endtask

  task automatic checkEvent();
    logic [11:0] expMask;
    longint earliest;
    longint expDelay;
    expMask = '0;
    for (int i = 0; i < 12; i++)
      if (nextExp[i] == tPrev) expMask[i] = 1'b1;
    chk(evMask == expMask, "R3 mask", evMask, expMask);
    for (int i = 0; i < 12; i++) begin
      if (expMask[i]) begin
        nExp[i]++;
        nextExp[i] += base[i] + ((odd[i] && (nExp[i] % 2 == 0)) ? 1 : 0);
      end
      if (evMask[i]) begin
        seenCnt[i]++;
        if (odd[i] && seenCnt[i] >= 2)
          chk(tPrev - lastSeen[i] == base[i] + (((seenCnt[i] - 1) % 2 == 0) ? 1 : 0),
              "R5 odd interval", tPrev - lastSeen[i],
              base[i] + (((seenCnt[i] - 1) % 2 == 0) ? 1 : 0));
        lastSeen[i] = tPrev;
      end
    end
    earliest = nextExp[0];
    for (int i = 1; i < 12; i++)
      if (nextExp[i] < earliest) earliest = nextExp[i];
    expDelay = earliest - tPrev - 1;
    chk(evDelay == expDelay, "R4 delay", evDelay, expDelay);
    if (evCount == 0) begin
      chk(evMask == 12'd0, "R2 first mask", evMask, 0);
      chk(evDelay == 8'd118, "R2 first delay", evDelay, 118);
    end
    chk(evSlot == 6'(evCount), "R7 slot", evSlot, evCount % 64);
    tPrev += expDelay + 1;
    evCount++;
  endtask

  bit finished = 1'b0;

  initial begin
    bit awaitGap;
    bit holdPending;
    int lowRun;
    logic [11:0] hMask;
    logic [7:0] hDelay;
    logic [5:0] hSlot;
    int cyc;
    int totalEv;

    modelReset();
    repeat (3) @(negedge clk);
    chk(evValid == 1'b0, "R1 valid in reset", evValid, 0);
    chk(evSlot == 6'd0, "R1 slot in reset", evSlot, 0);
    rst = 1'b0;
    awaitGap = 1'b0; holdPending = 1'b0; lowRun = 0; cyc = 0; totalEv = 0;

    while (totalEv < 520) begin
      @(negedge clk);
      cyc++;
      evReady = ((cyc * 5) % 11) < 7 && !((cyc % 300) > 260);
      if (!evValid) begin
        lowRun++;
        if (holdPending) begin
          chk(1'b0, "R6 valid dropped", 0, 1);
          holdPending = 1'b0;
        end
      end else begin
        if (awaitGap) begin
          chk(lowRun == 12, "R8 gap", lowRun, 12);
          awaitGap = 1'b0;
        end
        if (holdPending) begin
          chk(evMask == hMask, "R6 mask held", evMask, hMask);
          chk(evDelay == hDelay, "R6 delay held", evDelay, hDelay);
          chk(evSlot == hSlot, "R6 slot held", evSlot, hSlot);
        end
        if (evReady) begin
          checkEvent();
          totalEv++;
          holdPending = 1'b0;
          awaitGap = 1'b1;
          lowRun = 0;
        end else begin
          holdPending = 1'b1;
          hMask = evMask; hDelay = evDelay; hSlot = evSlot;
        end
      end
      if (totalEv == 260 && evCount == 260) begin
        // mid-run reset; stream must restart from the beginning
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(evValid == 1'b0, "R1 valid after reset", evValid, 0);
        chk(evSlot == 6'd0, "R1 slot after reset", evSlot, 0);
        rst = 1'b0;
        modelReset();
        awaitGap = 1'b0; holdPending = 1'b0; lowRun = 0;
        totalEv++;
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule